// File: doc/BRIEF.md
# Modem Handshake Change Detector

This block watches four active-low handshake lines of a serial port: send-permission, peer-ready, ring indication and carrier presence. Each line passes through a synchroniser. Each synchronised line then feeds a change detector that sets a sticky flag. The host sees one 8-bit status byte. The low nibble holds the four change flags. The high nibble holds the present, active-high levels of the lines. A host that ignores modem semantics can use the four flags as general-purpose input-change detectors.

The host reads the byte with a one-cycle read strobe. During the strobe cycle the status output is the value read. On the clock edge that ends the strobe, the change flags clear. The block has no data stream, so no valid/ready handshake is involved and there is no back-pressure. The strobe is a plain control pin and is honoured in every cycle it is high.

An interrupt request is raised while any change flag is set and the interrupt enable input is high. The ring-indication flag differs from the other three flags. It marks only the end of a ring, when the line goes from low to high. The other three flags mark a change in either direction.

Top module: `modem_delta_watch`

## Requirements
- R1: A change of `send_ok_n` in either direction sets status bit 0.
- R2: A change of `peer_rdy_n` in either direction sets status bit 1.
- R3: Status bit 2 is set only when `ring_n` goes from low to high. A high-to-low change of `ring_n` leaves bit 2 at 0.
- R4: A change of `carrier_n` in either direction sets status bit 3.
- R5: A change flag stays set until it is read, including across further changes of its line. Changes on several lines set several flags together.
- R6: While `rd_stb` is high, `status` shows the byte being read. On the clock edge that samples `rd_stb` high, bits 3:0 clear. The exception is a bit whose line produces a qualifying change at that same edge: that bit is set again, so the change is not lost.
- R7: Status bits 7:4 are the inverted, synchronised levels of `carrier_n`, `ring_n`, `peer_rdy_n` and `send_ok_n`, from bit 7 down to bit 4.
- R8: `irq` is 1 exactly when `irq_en` is 1 and at least one of status bits 3:0 is 1.
- R9: After reset, with all lines held high, `status` is 0x00 and `irq` is 0.
- R10: A line driven just before clock edge k changes the level bit after edge k+1 and the flag bit after edge k+2, with the default two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_ok_n | input | 1 | Active-low send-permission line (flag bit 0, level bit 4) |
| peer_rdy_n | input | 1 | Active-low peer-ready line (flag bit 1, level bit 5) |
| ring_n | input | 1 | Active-low ring line (flag bit 2, level bit 6) |
| carrier_n | input | 1 | Active-low carrier line (flag bit 3, level bit 7) |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | One-cycle host read strobe; clears the change flags |
| status | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The read-and-clear function and the edge-set function can act on the same flag at the same clock edge. The bench provokes this by changing a line and then raising the read strobe exactly two clocks later, so the detector sets the flag at the edge that also samples the strobe. The byte read must still show the flag at 0 and the new level. The status after that edge must show the flag at 1, and a second read must return it.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  localparam int unsigned LINE_CNT = 4;
  localparam int unsigned IDX_SEND = 0;
  localparam int unsigned IDX_PEER = 1;
  localparam int unsigned IDX_RING = 2;
  localparam int unsigned IDX_CARR = 3;

  typedef enum logic {
    DET_ANY  = 1'b0,
    DET_RISE = 1'b1
  } det_mode_e;

  function automatic det_mode_e mode_of(input logic [LINE_CNT-1:0] rise_mask, input int unsigned idx);
    return rise_mask[idx] ? DET_RISE : DET_ANY;
  endfunction
endpackage

// File: rtl/mdw_sync.sv
module mdw_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_VAL}};

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VEC;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VEC;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mdw_edge.sv
module mdw_edge
  import mdw_pkg::*;
#(
  parameter int unsigned      WIDTH     = 4,
  parameter logic [WIDTH-1:0] RISE_MASK = 4'b0100,
  parameter logic             RST_VAL   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] set_evt
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= {WIDTH{RST_VAL}};
    else        prev_q <= lvl;
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_det
      if (RISE_MASK[i]) begin : g_rise
        assign set_evt[i] = lvl[i] & ~prev_q[i];
      end else begin : g_any
        assign set_evt[i] = lvl[i] ^ prev_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/mdw_flags.sv
module mdw_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_evt,
  input  logic             rd_stb,
  output logic [WIDTH-1:0] flag_q
);
  logic [WIDTH-1:0] keep;

  assign keep = rd_stb ? '0 : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= keep | set_evt;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((flag_q & ~$past(set_evt)) == '0)); // R6

  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((flag_q & $past(set_evt)) == $past(set_evt))); // R6
endmodule

// File: rtl/modem_delta_watch.sv
module modem_delta_watch
  import mdw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_ok_n,
  input  logic       peer_rdy_n,
  input  logic       ring_n,
  input  logic       carrier_n,
  input  logic       irq_en,
  input  logic       rd_stb,
  output logic [7:0] status,
  output logic       irq
);
  localparam logic [LINE_CNT-1:0] RISE_MASK = LINE_CNT'(1) << IDX_RING;

  logic [LINE_CNT-1:0] raw_n;
  logic [LINE_CNT-1:0] lvl_n;
  logic [LINE_CNT-1:0] evt;
  logic [LINE_CNT-1:0] flags;

  assign raw_n[IDX_SEND] = send_ok_n;
  assign raw_n[IDX_PEER] = peer_rdy_n;
  assign raw_n[IDX_RING] = ring_n;
  assign raw_n[IDX_CARR] = carrier_n;

  mdw_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_n), .q_sync(lvl_n)
  );

  mdw_edge #(.WIDTH(LINE_CNT), .RISE_MASK(RISE_MASK), .RST_VAL(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_n), .set_evt(evt)
  );

  mdw_flags #(.WIDTH(LINE_CNT)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(evt), .rd_stb(rd_stb), .flag_q(flags)
  );

  assign status = {~lvl_n, flags};
  assign irq    = irq_en & (|flags);

  AST_RING_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lvl_n[IDX_RING]) && !status[IDX_RING]) |=> !status[IDX_RING]); // R3

  AST_SEND_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_n[IDX_SEND] != $past(lvl_n[IDX_SEND])) |=> status[IDX_SEND]); // R1

  AST_PEER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_n[IDX_PEER] != $past(lvl_n[IDX_PEER])) |=> status[IDX_PEER]); // R2

  AST_CARR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_n[IDX_CARR] != $past(lvl_n[IDX_CARR])) |=> status[IDX_CARR]); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || status[3:0] == 4'h0) |-> !irq); // R8
endmodule

// File: tb/modem_delta_watch_test.sv
module modem_delta_watch_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [3:0] pin_n;
  logic       irq_en;
  logic       rd_stb;
  logic [7:0] status;
  logic       irq;

  modem_delta_watch uut (
    .clk(clk), .rst_n(rst_n),
    .send_ok_n(pin_n[0]), .peer_rdy_n(pin_n[1]), .ring_n(pin_n[2]), .carrier_n(pin_n[3]),
    .irq_en(irq_en), .rd_stb(rd_stb), .status(status), .irq(irq)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_item_t;

  exp_item_t  sb_q[$];
  logic [3:0] exp_flag;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {~pin_n, exp_flag};
  endfunction

  // driver: change one line, update the model, wait for the flag to land
  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    if (pin_n[idx] != v && (idx != 2 || v == 1'b1)) exp_flag[idx] = 1'b1;
    pin_n[idx] = v;
    repeat (3) @(negedge clk);
  endtask

  // driver: one-cycle read, expected byte goes to the scoreboard
  task automatic do_read(input string tag);
    @(negedge clk);
    rd_stb = 1'b1;
    sb_q.push_back('{val: exp_status(), tag: tag});
    exp_flag = 4'h0;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_stb) begin
        if (sb_q.size() == 0) chk(1'b0, "scoreboard empty on read", status, 8'h00);
        else begin
          exp_item_t e;
          e = sb_q.pop_front();
          chk(status == e.val, e.tag, status, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_n = 4'hF; irq_en = 1'b0; rd_stb = 1'b0; exp_flag = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(status == 8'h00, "R9 reset status", status, 8'h00);
    chk(irq == 1'b0, "R9 reset irq", {7'd0, irq}, 8'h00);

    irq_en = 1'b1;
    set_pin(0, 1'b0);
    #1;
    chk(irq == 1'b1, "R8 irq with flag and enable", {7'd0, irq}, 8'h01);
    do_read("R1 send line fall");
    #1;
    chk(status == exp_status(), "R6 flags cleared after read", status, exp_status());
    chk(irq == 1'b0, "R8 irq drops after read", {7'd0, irq}, 8'h00);
    set_pin(0, 1'b1);
    do_read("R1 send line rise");

    set_pin(2, 1'b0);
    #1;
    chk(status == 8'h40, "R3 ring fall sets no flag", status, 8'h40);
    chk(irq == 1'b0, "R8 no irq without flag", {7'd0, irq}, 8'h00);
    set_pin(2, 1'b1);
    do_read("R3 ring rise");

    set_pin(1, 1'b0);
    do_read("R2 peer line fall");
    set_pin(1, 1'b1);
    do_read("R2 peer line rise");

    set_pin(3, 1'b0);
    do_read("R4 carrier fall");
    set_pin(3, 1'b1);
    do_read("R4 carrier rise");

    set_pin(0, 1'b0);
    set_pin(0, 1'b1);
    do_read("R5 flag sticky across two changes");

    @(negedge clk);
    pin_n[3] = 1'b0; pin_n[1] = 1'b0; exp_flag = 4'b1010;
    repeat (3) @(negedge clk);
    do_read("R5 R7 two lines at once");

    irq_en = 1'b0;
    set_pin(3, 1'b1);
    #1;
    chk(irq == 1'b0, "R8 irq masked by enable", {7'd0, irq}, 8'h00);
    @(negedge clk);
    irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R8 irq on enable", {7'd0, irq}, 8'h01);
    do_read("R4 carrier rise under mask");

    // latency R10: peer line back high
    @(negedge clk);
    pin_n[1] = 1'b1;
    @(negedge clk);
    #1;
    chk(status == 8'h20, "R10 one edge: nothing yet", status, 8'h20);
    @(negedge clk);
    #1;
    chk(status == 8'h00, "R10 two edges: level only", status, 8'h00);
    @(negedge clk);
    #1;
    chk(status == 8'h02, "R10 three edges: flag set", status, 8'h02);
    exp_flag = 4'b0010;
    do_read("R10 peer flag read");

    // same-cycle read and edge, R6
    @(negedge clk);
    pin_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    rd_stb = 1'b1;
    sb_q.push_back('{val: 8'h10, tag: "R6 read in edge cycle"});
    @(negedge clk);
    rd_stb = 1'b0;
    #1;
    chk(status == 8'h11, "R6 flag kept after coinciding read", status, 8'h11);
    exp_flag = 4'b0001;
    do_read("R6 kept flag read back");
    #1;
    chk(status == 8'h10, "R7 level stays after clear", status, 8'h10);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule